// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Vector Controller

This block gathers eight interrupt sources into one vectored request for a processor core. The sources are four external active-low pins, overflow pulses from two timers, and held request levels from a third timer and a serial port. Each source has its own enable bit and its own priority bit, and one global enable gates them all. The controller picks the winning source and presents its vector address together with a request line.

Each external pin is synchronized first. It then acts either as a low-level request or as a falling-edge request. In edge mode a hardware flag latches the edge and clears when the core accepts that vector. The core accepts a vector with a one-cycle acknowledge and ends a service routine with a return strobe. The controller tracks which priority levels are in service, so a high-priority request can interrupt a low-priority routine but a request can never interrupt its own level.

Three byte-wide registers are written and read through a simple select/write-enable port: the enable register, the priority register, and a control register for the two extra external pins. The edge/level selection for the first two external pins comes from a port, because its register belongs to the timer block.

Top module: `pri_irq_hub`

## Requirements
- R1: The vector address is 03h + 8 × source index. Source indices are: ext0=0 (03h), timer0=1 (0Bh), ext1=2 (13h), timer1=3 (1Bh), serial=4 (23h), timer2=5 (2Bh), ext2=6 (33h), ext3=7 (3Bh).
- R2: Among pending sources at the same priority level, the lowest index wins.
- R3: A source raises a request only when its enable bit is 1 and the global enable (enable register bit 7) is 1. While the global enable is 0, vec_req_o stays low.
- R4: A pending source whose priority bit is 1 wins over every pending source whose priority bit is 0, whatever their indices.
- R5: After a low-level vector is acknowledged, only high-priority sources may request. After a high-level vector is acknowledged, no source may request.
- R6: A reti_i pulse clears the high in-service level if it is set, and otherwise clears the low level.
- R7: External pins pass through a two-flop synchronizer. In level mode (type 0) a pin requests while its synchronized value is low. In edge mode (type 1) a falling edge sets the pin's flag, the flag requests, and acceptance of that pin's vector clears the flag.
- R8: A timer0 or timer1 overflow pulse sets a flag that acceptance of its vector clears. The timer2 and serial requests are level inputs and are not changed by acceptance.
- R9: reg_sel_i selects the register: 0 = enable {global, 0, t2, ser, t1, ext1, t0, ext0}, 1 = priority {0, 0, t2, ser, t1, ext1, t0, ext0}, 2 = extra control {pri3, en3, flag3, type3, pri2, en2, flag2, type2}. All three read 00h after reset, and select 3 reads 00h.
- R10: The flag2 and flag3 bits of the extra control register read the hardware edge flags, and a register write sets or clears them directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_n_i | input | 4 | External interrupt pins, active low, bit i = ext i |
| ext01_edge_i | input | 2 | Edge mode select for ext0 (bit 0) and ext1 (bit 1) |
| tmr_ovf_i | input | 2 | Overflow pulses of timer0 (bit 0) and timer1 (bit 1) |
| tmr2_req_i | input | 1 | Timer2 request level |
| ser_req_i | input | 1 | Serial port request level |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data of the selected register |
| ext01_flag_o | output | 2 | Edge flags of ext0 and ext1 |
| vec_req_o | output | 1 | Vector request to the core |
| vec_addr_o | output | 8 | Vector address of the winning source |
| vec_ack_i | input | 1 | Core accepts the presented vector |
| reti_i | input | 1 | Return-from-interrupt strobe |

## Verification
The bench targets the orderings that are easy to get wrong. Serial must beat timer2 at equal level, and a priority bit must beat a lower index; a design with the polling reversed or the priority ignored would return the wrong vector address. It then walks a nested service sequence. A design without level tracking would re-request at the level already in service, and one whose return clears the wrong level would never release the high-level source. Flag tests check that edge flags and timer flags clear on acceptance while a held pin, timer2 and serial do not retrigger or stay cleared wrongly. A design that cleared on the wrong vector or re-armed in level fashion would show a request after the return.

// File: rtl/pri_irq_pkg.sv
package pri_irq_pkg;
  localparam int N_SRC = 8;
  localparam int N_EXT = 4;
  localparam int IDX_W = $clog2(N_SRC);
  localparam int VEC_W = 8;

  // source index of each external pin in polling order
  function automatic int unsigned ext_src(input int unsigned e);
    case (e)
      0:       return 0;
      1:       return 2;
      2:       return 6;
      default: return 7;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_W'({idx, 3'b011});
  endfunction
endpackage

// File: rtl/irq_pin_cond.sv
module irq_pin_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic edge_mode_i,
  input  logic sw_we_i,
  input  logic sw_val_i,
  input  logic clr_i,
  output logic req_o,
  output logic flag_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, flag_q, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
      prev_q <= sync_q[MSB];
    end
  end

  assign fall = prev_q & ~sync_q[MSB];

  // hardware edge wins over software write and over acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  flag_q <= 1'b0;
    else if (edge_mode_i && fall) flag_q <= 1'b1;
    else if (sw_we_i)             flag_q <= sw_val_i;
    else if (clr_i)               flag_q <= 1'b0;
  end

  assign req_o  = edge_mode_i ? flag_q : ~sync_q[MSB];
  assign flag_o = flag_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign found_o = |req_i;
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic       take_hi_i,
  input  logic       reti_i,
  output logic [1:0] act_o
);
  logic [1:0] act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (reti_i) begin
      if (act_q[1]) act_d[1] = 1'b0;
      else          act_d[0] = 1'b0;
    end
    if (take_i) begin
      if (take_hi_i) act_d[1] = 1'b1;
      else           act_d[0] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_d;
  end

  assign act_o = act_q;
endmodule

// File: rtl/pri_irq_hub.sv
module pri_irq_hub
  import pri_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] ext_n_i,
  input  logic [1:0]       ext01_edge_i,
  input  logic [1:0]       tmr_ovf_i,
  input  logic             tmr2_req_i,
  input  logic             ser_req_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic [1:0]       ext01_flag_o,
  output logic             vec_req_o,
  output logic [VEC_W-1:0] vec_addr_o,
  input  logic             vec_ack_i,
  input  logic             reti_i
);
  localparam logic [1:0] SEL_EN  = 2'd0;
  localparam logic [1:0] SEL_PRI = 2'd1;
  localparam logic [1:0] SEL_XC  = 2'd2;

  logic [7:0] en_q;
  logic [5:0] pri_q;
  logic [1:0] xpri_q, xen_q, xtype_q;

  logic [N_EXT-1:0] pin_req, pin_flag, pin_edge, pin_swe, pin_swv, pin_clr;
  logic [1:0]       tflag_q;
  logic [N_SRC-1:0] src_raw, src_en, src_pri, pend, hi_cand, lo_cand;
  logic             hi_found, lo_found, take, win_hi;
  logic [IDX_W-1:0] hi_idx, lo_idx, win;
  logic [1:0]       act_lvl;

  // register file
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      pri_q   <= '0;
      xpri_q  <= '0;
      xen_q   <= '0;
      xtype_q <= '0;
    end else if (reg_we_i) begin
      case (reg_sel_i)
        SEL_EN:  en_q  <= reg_wdata_i & 8'hBF;
        SEL_PRI: pri_q <= reg_wdata_i[5:0];
        SEL_XC: begin
          xpri_q  <= {reg_wdata_i[7], reg_wdata_i[3]};
          xen_q   <= {reg_wdata_i[6], reg_wdata_i[2]};
          xtype_q <= {reg_wdata_i[4], reg_wdata_i[0]};
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_i)
      SEL_EN:  reg_rdata_o = en_q;
      SEL_PRI: reg_rdata_o = {2'b00, pri_q};
      SEL_XC:  reg_rdata_o = {xpri_q[1], xen_q[1], pin_flag[3], xtype_q[1],
                              xpri_q[0], xen_q[0], pin_flag[2], xtype_q[0]};
      default: reg_rdata_o = '0;
    endcase
  end

  // external pins
  assign pin_edge = {xtype_q, ext01_edge_i};
  assign pin_swe  = {{2{reg_we_i && reg_sel_i == SEL_XC}}, 2'b00};
  assign pin_swv  = {reg_wdata_i[5], reg_wdata_i[1], 2'b00};

  for (genvar e = 0; e < N_EXT; e++) begin : g_pin
    assign pin_clr[e] = take && (win == IDX_W'(ext_src(e)));
    irq_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pin_ni      (ext_n_i[e]),
      .edge_mode_i (pin_edge[e]),
      .sw_we_i     (pin_swe[e]),
      .sw_val_i    (pin_swv[e]),
      .clr_i       (pin_clr[e]),
      .req_o       (pin_req[e]),
      .flag_o      (pin_flag[e])
    );
  end

  assign ext01_flag_o = pin_flag[1:0];

  // timer0/1 overflow flags
  for (genvar t = 0; t < 2; t++) begin : g_tflag
    localparam logic [IDX_W-1:0] TIDX = IDX_W'(2 * t + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     tflag_q[t] <= 1'b0;
      else if (tmr_ovf_i[t])           tflag_q[t] <= 1'b1;
      else if (take && win == TIDX)    tflag_q[t] <= 1'b0;
    end
  end

  assign src_raw = {pin_req[3], pin_req[2], tmr2_req_i, ser_req_i,
                    tflag_q[1], pin_req[1], tflag_q[0], pin_req[0]};
  assign src_en  = {xen_q, en_q[5:0]};
  assign src_pri = {xpri_q, pri_q};
  assign pend    = src_raw & src_en & {N_SRC{en_q[7]}};
  assign hi_cand = pend & src_pri & {N_SRC{~act_lvl[1]}};
  assign lo_cand = pend & ~src_pri & {N_SRC{~(act_lvl[1] | act_lvl[0])}};

  irq_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick_hi (
    .req_i(hi_cand), .found_o(hi_found), .idx_o(hi_idx)
  );
  irq_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick_lo (
    .req_i(lo_cand), .found_o(lo_found), .idx_o(lo_idx)
  );

  assign win_hi     = hi_found;
  assign win        = hi_found ? hi_idx : lo_idx;
  assign vec_req_o  = hi_found | lo_found;
  assign vec_addr_o = vec_of(win);
  assign take       = vec_req_o & vec_ack_i;

  irq_level_track u_lvl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .take_hi_i (win_hi),
    .reti_i    (reti_i),
    .act_o     (act_lvl)
  );
endmodule

// File: rtl/pri_irq_hub_chk.sv
module pri_irq_hub_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vec_req_o,
  input logic [7:0] vec_addr_o,
  input logic       vec_ack_i,
  input logic       reti_i,
  input logic [1:0] tmr_ovf_i,
  input logic       ea_i,
  input logic [1:0] act_i,
  input logic       t0_flag_i
);
  // R1
  vec_addr_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> vec_addr_o[2:0] == 3'b011);

  // R3
  global_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ea_i |-> !vec_req_o);

  // R5
  hi_blocks_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i[1] |-> !vec_req_o);

  // R5
  take_marks_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_o && vec_ack_i) |=> (act_i != 2'b00));

  // R6
  reti_hi_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && act_i[1] && !vec_ack_i) |=> !act_i[1]);

  // R8
  t0_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_o && vec_ack_i && vec_addr_o == 8'h0B && !tmr_ovf_i[0]) |=> !t0_flag_i);
endmodule

bind pri_irq_hub pri_irq_hub_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vec_req_o  (vec_req_o),
  .vec_addr_o (vec_addr_o),
  .vec_ack_i  (vec_ack_i),
  .reti_i     (reti_i),
  .tmr_ovf_i  (tmr_ovf_i),
  .ea_i       (en_q[7]),
  .act_i      (act_lvl),
  .t0_flag_i  (tflag_q[0])
);

// File: tb/pri_irq_hub_tb_top.sv
`timescale 1ns/1ps
module pri_irq_hub_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_n = 4'hF;
  logic [1:0] ext01_edge = 2'b00;
  logic [1:0] tmr_ovf = 2'b00;
  logic       tmr2_req = 1'b0, ser_req = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] ext01_flag;
  logic       vec_req;
  logic [7:0] vec_addr;
  logic       vec_ack = 1'b0, reti = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pri_irq_hub dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_n_i(ext_n), .ext01_edge_i(ext01_edge),
    .tmr_ovf_i(tmr_ovf), .tmr2_req_i(tmr2_req), .ser_req_i(ser_req),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .ext01_flag_o(ext01_flag), .vec_req_o(vec_req),
    .vec_addr_o(vec_addr), .vec_ack_i(vec_ack), .reti_i(reti)
  );

  // {en, pri, xc, pins_n, tmr2, ser, exp_req, exp_addr}
  localparam int NV = 11;
  localparam logic [38:0] VEC_TBL [NV] = '{
    {8'h81, 8'h00, 8'h00, 4'b1110, 1'b0, 1'b0, 1'b1, 8'h03},
    {8'h01, 8'h00, 8'h00, 4'b1110, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'hBF, 8'h00, 8'h00, 4'b0000, 1'b1, 1'b1, 1'b1, 8'h03},
    {8'hBF, 8'h00, 8'h44, 4'b0011, 1'b0, 1'b0, 1'b1, 8'h33},
    {8'hBF, 8'h00, 8'hC4, 4'b0011, 1'b0, 1'b0, 1'b1, 8'h3B},
    {8'hBF, 8'h10, 8'h00, 4'b0000, 1'b0, 1'b1, 1'b1, 8'h23},
    {8'hBF, 8'h00, 8'h00, 4'b1111, 1'b1, 1'b1, 1'b1, 8'h23},
    {8'hBF, 8'h20, 8'h00, 4'b1111, 1'b1, 1'b1, 1'b1, 8'h2B},
    {8'hA0, 8'h00, 8'h00, 4'b1111, 1'b0, 1'b1, 1'b0, 8'h00},
    {8'h84, 8'h00, 8'h00, 4'b1101, 1'b0, 1'b0, 1'b1, 8'h13},
    {8'h80, 8'h00, 8'h04, 4'b1011, 1'b0, 1'b0, 1'b1, 8'h33}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] sel, output logic [7:0] val);
    reg_sel = sel;
    #1 val = reg_rdata;
  endtask

  task automatic pulse_ack();
    @(negedge clk); vec_ack = 1'b1;
    @(negedge clk); vec_ack = 1'b0;
  endtask

  task automatic pulse_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ext_n = 4'hF; ext01_edge = 2'b00; tmr_ovf = 2'b00;
    tmr2_req = 1'b0; ser_req = 1'b0; vec_ack = 1'b0; reti = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic chk_vec(input string tag, input logic exp_req, input logic [7:0] exp_addr);
    chk(tag, {7'b0, vec_req}, {7'b0, exp_req});
    if (exp_req) chk(tag, vec_addr, exp_addr);
  endtask

  initial begin
    logic [7:0] rd;
    do_reset();

    // R9 reset state
    chk_vec("R9 reset req", 1'b0, 8'h00);
    rreg(2'd0, rd); chk("R9 reset enable", rd, 8'h00);
    rreg(2'd1, rd); chk("R9 reset priority", rd, 8'h00);
    rreg(2'd2, rd); chk("R9 reset xctl", rd, 8'h00);
    rreg(2'd3, rd); chk("R9 unused select", rd, 8'h00);

    // table walk: level mode, no acceptance, R1 R2 R3 R4 R7
    for (int k = 0; k < NV; k++) begin
      logic [38:0] v;
      v = VEC_TBL[k];
      wreg(2'd0, v[38:31]);
      wreg(2'd1, v[30:23]);
      wreg(2'd2, v[22:15]);
      @(negedge clk);
      ext_n = v[14:11]; tmr2_req = v[10]; ser_req = v[9];
      cyc(4);
      chk_vec($sformatf("R1 R2 R3 R4 R7 vector %0d", k), v[8], v[7:0]);
      rreg(2'd0, rd); chk("R9 enable readback", rd, v[38:31] & 8'hBF);
    end
    @(negedge clk); ext_n = 4'hF; tmr2_req = 1'b0; ser_req = 1'b0;

    // R5 R6 nesting
    do_reset();
    wreg(2'd0, 8'h85);
    ext_n = 4'b1101;
    cyc(4);
    chk_vec("R5 low ext1 request", 1'b1, 8'h13);
    pulse_ack();
    chk_vec("R5 low in service blocks", 1'b0, 8'h00);
    ext_n = 4'b1100;
    cyc(4);
    chk_vec("R5 same level no preempt", 1'b0, 8'h00);
    wreg(2'd1, 8'h01);
    cyc(1);
    chk_vec("R5 high preempts low", 1'b1, 8'h03);
    pulse_ack();
    chk_vec("R5 high in service blocks", 1'b0, 8'h00);
    pulse_reti();
    chk_vec("R6 reti frees high", 1'b1, 8'h03);
    wreg(2'd1, 8'h00);
    cyc(1);
    chk_vec("R6 low still in service", 1'b0, 8'h00);
    pulse_reti();
    chk_vec("R6 reti frees low", 1'b1, 8'h03);

    // R7 edge mode ext0
    do_reset();
    ext01_edge = 2'b01;
    wreg(2'd0, 8'h81);
    cyc(4);
    chk_vec("R7 no edge no request", 1'b0, 8'h00);
    ext_n = 4'b1110;
    cyc(4);
    chk("R7 edge flag set", {6'b0, ext01_flag}, 8'h01);
    chk_vec("R7 edge request", 1'b1, 8'h03);
    pulse_ack();
    chk("R7 flag cleared on accept", {6'b0, ext01_flag}, 8'h00);
    pulse_reti();
    cyc(2);
    chk_vec("R7 held low pin no retrigger", 1'b0, 8'h00);

    // R8 timer flags
    do_reset();
    wreg(2'd0, 8'h82);
    @(negedge clk); tmr_ovf = 2'b01;
    @(negedge clk); tmr_ovf = 2'b00;
    chk_vec("R8 timer0 request", 1'b1, 8'h0B);
    pulse_ack();
    pulse_reti();
    chk_vec("R8 timer0 flag cleared", 1'b0, 8'h00);
    wreg(2'd0, 8'h88);
    @(negedge clk); tmr_ovf = 2'b10;
    @(negedge clk); tmr_ovf = 2'b00;
    chk_vec("R8 timer1 request", 1'b1, 8'h1B);
    pulse_ack();
    pulse_reti();
    chk_vec("R8 timer1 flag cleared", 1'b0, 8'h00);
    wreg(2'd0, 8'hA0);
    tmr2_req = 1'b1;
    cyc(1);
    chk_vec("R8 timer2 request", 1'b1, 8'h2B);
    pulse_ack();
    pulse_reti();
    chk_vec("R8 timer2 not cleared", 1'b1, 8'h2B);
    tmr2_req = 1'b0;

    // R10 ext2 flag in extra control register
    do_reset();
    wreg(2'd0, 8'h80);
    wreg(2'd2, 8'h05);
    ext_n = 4'b1011;
    cyc(4);
    rreg(2'd2, rd); chk("R10 hw flag visible", rd, 8'h07);
    chk_vec("R7 ext2 edge request", 1'b1, 8'h33);
    pulse_ack();
    rreg(2'd2, rd); chk("R10 flag cleared on accept", rd, 8'h05);
    pulse_reti();
    chk_vec("R10 no request after clear", 1'b0, 8'h00);
    wreg(2'd2, 8'h07);
    cyc(1);
    chk_vec("R10 software set flag", 1'b1, 8'h33);
    wreg(2'd2, 8'h05);
    cyc(1);
    chk_vec("R10 software clear flag", 1'b0, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule